// File: doc/BRIEF.md
# Conversion Scheduler with Bus Abort

This block decides when a measurement converter runs. In periodic mode it issues a start strobe on a fixed cycle interval. In triggered mode it waits for a rising edge on an external convert-start pin. While any conversion is running or waiting, the busy flag is high. A finished conversion raises a one-cycle done pulse and loads the sampled value into the result register.

Serial bus activity is reported by the bus slave as a busy level, high from START to STOP. If this level is high during a conversion, the conversion is aborted. The scheduler keeps the request pending and starts the conversion again once the bus is idle. An aborted conversion leaves the previous result in place.

The converter is modelled as a counter with a fixed latency. A separate test input turns the bus glitch filter off. The mode input is read only while the scheduler is idle, so changing it never cuts a conversion short.

Top module: `conv_sched`

## Requirements
- R1: While reset is asserted and after its release, conv_start_o, conv_busy_o and conv_done_o are 0 and result_o is 0.
- R2: filt_en_o is 1 when filt_dis_i is 0, and 0 when filt_dis_i is 1.
- R3: With mode_trig_i = 0 and the bus idle, conv_start_o pulses for one cycle every PERIOD_CYC cycles.
- R4: After a start pulse, conv_busy_o stays 1 and conv_done_o pulses exactly CONV_LAT cycles later, as conv_busy_o falls. At that pulse result_o equals sample_i.
- R5: With mode_trig_i = 1, a 0-to-1 change of conv_pin_i produces a start pulse 3 clock cycles later. No start occurs without such a change.
- R6: Rising edges of conv_pin_i that are detected while a conversion is running are ignored and cause no later start.
- R7: bus_busy_i going high while a conversion runs aborts it. In that case conv_done_o does not pulse, result_o keeps its previous value, and conv_busy_o stays 1.
- R8: After an abort, a start pulse follows 3 cycles after bus_busy_i returns to 0, and that conversion completes normally.
- R9: A start request that arrives while bus_busy_i is 1 and the scheduler is idle is deferred. conv_busy_o rises, and the start pulse comes 3 cycles after bus_busy_i returns to 0.
- R10: A change of mode_trig_i during a conversion does not shorten that conversion. The new mode governs only the requests that follow.
- R11: conv_start_o and conv_done_o are never 1 in the same cycle. result_o changes only in a cycle where conv_done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_trig_i | input | 1 | 0 = periodic conversions, 1 = pin-triggered conversions |
| filt_dis_i | input | 1 | Test bit; 1 disables the bus input filter |
| conv_pin_i | input | 1 | Asynchronous convert-start pin |
| bus_busy_i | input | 1 | Asynchronous bus transaction level, high from START to STOP |
| sample_i | input | DATA_W | Converter output value, captured when a conversion completes |
| conv_start_o | output | 1 | One-cycle converter start strobe |
| conv_busy_o | output | 1 | A conversion is running or pending |
| conv_done_o | output | 1 | One-cycle pulse when a conversion completes |
| result_o | output | DATA_W | Last value from a completed conversion |
| filt_en_o | output | 1 | Enable for the bus input glitch filter |

## Verification
The bench sweeps the cycle at which bus traffic begins across the whole conversion, including the offsets where it arrives too late to abort. It computes from the synchroniser depth and the latency whether each offset aborts. A design that let completion win over abort, or that dropped the pending request, would report a stale result or never restart. The bench pulses the pin during a conversion and switches the mode mid-conversion, which exposes a design that latches edges or resets the converter when the mode changes. A request made while the bus is already busy must wait for the bus to go idle. Periodic start pulses must come exactly one interval apart, which catches off-by-one errors in the timer.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } sched_st_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cs_timer.sv
module cs_timer #(
  parameter int PERIOD = 355
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/cs_adc_model.sv
// Fixed-latency stand-in for the analog converter.
module cs_adc_model #(
  parameter int LATENCY = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic done_o
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign done_o = run_q && (cnt_q == LAST) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int PERIOD_CYC  = 355,
  parameter int CONV_LAT    = 40,
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_trig_i,
  input  logic              filt_dis_i,
  input  logic              conv_pin_i,
  input  logic              bus_busy_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              conv_start_o,
  output logic              conv_busy_o,
  output logic              conv_done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              filt_en_o
);
  logic [1:0] async_in, sync_out;
  logic       pin_s, busy_s, pin_d_q, pin_rise;
  logic       tick, req, adc_done;
  logic       start_c, abort_c;
  logic       start_q, done_q;
  logic [DATA_W-1:0] result_q;
  sched_st_e  st_q, st_d;

  assign async_in = {bus_busy_i, conv_pin_i};

  cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (sync_out)
  );

  assign pin_s  = sync_out[0];
  assign busy_s = sync_out[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_d_q <= 1'b0;
    else         pin_d_q <= pin_s;
  end

  assign pin_rise = pin_s && !pin_d_q;

  cs_timer #(.PERIOD(PERIOD_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (!mode_trig_i),
    .tick_o(tick)
  );

  // mode only matters at the idle decision point
  assign req = mode_trig_i ? pin_rise : tick;

  cs_adc_model #(.LATENCY(CONV_LAT)) u_adc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_c),
    .abort_i(abort_c),
    .done_o (adc_done)
  );

  always_comb begin
    st_d    = st_q;
    start_c = 1'b0;
    abort_c = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          if (busy_s) st_d = ST_HOLD;
          else begin
            st_d    = ST_CONV;
            start_c = 1'b1;
          end
        end
      end
      ST_CONV: begin
        // bus activity wins over a coincident completion
        if (busy_s) begin
          st_d    = ST_HOLD;
          abort_c = 1'b1;
        end else if (adc_done) begin
          st_d = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!busy_s) begin
          st_d    = ST_CONV;
          start_c = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_c;
      done_q  <= adc_done;
      if (adc_done) result_q <= sample_i;
    end
  end

  assign conv_start_o = start_q;
  assign conv_busy_o  = (st_q != ST_IDLE);
  assign conv_done_o  = done_q;
  assign result_o     = result_q;
  assign filt_en_o    = !filt_dis_i;
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_start_o,
  input logic              conv_busy_o,
  input logic              conv_done_o,
  input logic [DATA_W-1:0] result_o
);
  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> conv_busy_o);

  p_done_ends_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (!conv_busy_o && $past(conv_busy_o)));

  p_busy_fall_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_busy_o) |-> conv_done_o);

  p_start_done_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_start_o && conv_done_o));

  p_result_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_o |-> $stable(result_o));
endmodule

bind conv_sched conv_sched_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_start_o(conv_start_o),
  .conv_busy_o (conv_busy_o),
  .conv_done_o (conv_done_o),
  .result_o    (result_o)
);

// File: tb/conv_sched_tb.sv
`timescale 1ns/1ps
module conv_sched_tb;
  localparam int PER = 20;
  localparam int LAT = 6;
  localparam int DW  = 10;
  localparam int SYN = 3;  // pin/bus change to start pulse, in cycles

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_trig = 1'b1;
  logic          filt_dis = 1'b0;
  logic          pin = 1'b0;
  logic          bus = 1'b0;
  logic [DW-1:0] sample = '0;
  logic          start_o, busy_o, done_o, filt_en_o;
  logic [DW-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] prev_res;

  always #10 clk = ~clk;

  conv_sched #(.PERIOD_CYC(PER), .CONV_LAT(LAT), .DATA_W(DW)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mode_trig_i (mode_trig),
    .filt_dis_i  (filt_dis),
    .conv_pin_i  (pin),
    .bus_busy_i  (bus),
    .sample_i    (sample),
    .conv_start_o(start_o),
    .conv_busy_o (busy_o),
    .conv_done_o (done_o),
    .result_o    (result_o),
    .filt_en_o   (filt_en_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!start_o && n < 200) begin step(); n++; end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 200) begin step(); n++; end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int n, starts, dones;
    // R1 reset state
    step(); step();
    chk(!start_o && !busy_o && !done_o && result_o == 0, "R1",
        {start_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    step(); step();
    chk(!start_o && !busy_o && !done_o && result_o == 0, "R1",
        {start_o, busy_o, done_o}, 0);

    // R2 filter enable
    for (int f = 0; f < 2; f++) begin
      filt_dis = f[0];
      #1;
      chk(filt_en_o == !f[0], "R2", filt_en_o, !f[0]);
    end
    filt_dis = 1'b0;

    // R5 no start without an edge
    starts = 0;
    for (int i = 0; i < 30; i++) begin step(); if (start_o) starts++; end
    chk(starts == 0, "R5", starts, 0);

    // R5/R4 triggered conversions over several samples
    for (int v = 0; v < 4; v++) begin
      sample = DW'(v * 173 + 5);
      pin = 1'b1;
      step(); chk(!start_o, "R5", start_o, 0);
      step(); chk(!start_o, "R5", start_o, 0);
      step(); chk(start_o && busy_o, "R5", start_o, 1);
      pin = 1'b0;
      wait_done(n);
      chk(n == LAT, "R4", n, LAT);
      chk(result_o == sample && !busy_o, "R4", result_o, sample);
      step(); step();
    end

    // R6 edges during a conversion are ignored
    sample = 10'd77;
    pin = 1'b1;
    wait_start(n);
    chk(n == SYN, "R5", n, SYN);
    pin = 1'b0; step();
    pin = 1'b1; step();
    pin = 1'b0;
    starts = 0;
    for (int i = 0; i < 20; i++) begin step(); if (start_o) starts++; end
    chk(starts == 0, "R6", starts, 0);
    chk(result_o == 10'd77, "R6", result_o, 77);

    // R7/R8 sweep of bus-traffic offset across the conversion
    for (int k = 0; k < LAT + 2; k++) begin
      bit exp_abort;
      exp_abort = (k + SYN <= LAT);
      prev_res = result_o;
      sample = DW'(300 + k);
      pin = 1'b1;
      wait_start(n);
      pin = 1'b0;
      for (int i = 0; i < k; i++) step();
      bus = 1'b1;
      if (exp_abort) begin
        dones = 0;
        for (int i = 0; i < 8; i++) begin step(); if (done_o) dones++; end
        chk(dones == 0, "R7", dones, 0);
        chk(busy_o, "R7", busy_o, 1);
        chk(result_o == prev_res, "R7", result_o, prev_res);
        bus = 1'b0;
        step(); step(); step();
        chk(start_o, "R8", start_o, 1);
        wait_done(n);
        chk(n == LAT, "R8", n, LAT);
        chk(result_o == sample, "R8", result_o, sample);
      end else begin
        wait_done(n);
        chk(result_o == sample, "R7", result_o, sample);
        for (int i = 0; i < 6; i++) step();
        bus = 1'b0;
        starts = 0;
        for (int i = 0; i < 10; i++) begin step(); if (start_o) starts++; end
        chk(starts == 0 && !busy_o, "R8", starts, 0);
      end
      step(); step();
    end

    // R9 request while the bus is busy is deferred
    bus = 1'b1;
    for (int i = 0; i < 4; i++) step();
    sample = 10'd512;
    pin = 1'b1;
    starts = 0;
    for (int i = 0; i < 8; i++) begin step(); if (start_o) starts++; end
    chk(starts == 0, "R9", starts, 0);
    chk(busy_o, "R9", busy_o, 1);
    bus = 1'b0;
    step(); step();
    chk(!start_o, "R9", start_o, 0);
    step();
    chk(start_o, "R9", start_o, 1);
    pin = 1'b0;
    wait_done(n);
    chk(result_o == 10'd512, "R9", result_o, 512);

    // R3 periodic mode
    step();
    mode_trig = 1'b0;
    wait_start(n);
    for (int j = 0; j < 4; j++) begin
      sample = DW'(600 + j);
      step();
      n = 1;
      while (!start_o && n < 200) begin step(); n++; end
      chk(n == PER, "R3", n, PER);
    end

    // R10 mode change mid-conversion does not shorten it
    sample = 10'd999;
    mode_trig = 1'b1;
    wait_done(n);
    chk(n == LAT, "R10", n, LAT);
    chk(result_o == 10'd999, "R10", result_o, 999);
    starts = 0;
    for (int i = 0; i < 2 * PER; i++) begin step(); if (start_o) starts++; end
    chk(starts == 0, "R10", starts, 0);

    finish_run();
  end
endmodule